// File: doc/BRIEF.md
# Configuration Cycle Access Engine

This block accepts one configuration request at a time from the host side and turns it into dword accesses on an external configuration bus. Each request names a bus number, device, function, register offset, access size, write data and direction. For bus 0 the engine builds a Type 0 address. In that address the target device is picked by a one-hot select bit, and the upper select bits are placed in a window register. For any other bus it builds a Type 1 address with the bus, device and function fields packed in.

The external bus is a plain dword port: a held request, a one-cycle acknowledge, read data and a fault flag. Reads return the addressed bytes shifted down to bit 0. A byte or halfword write becomes a read of the aligned dword, a lane merge and a write-back. A full dword write is a single bus write. Every request ends with a one-cycle done pulse that carries a status and the read result.

Top module: `cfg_access_engine`

## Requirements
- R1: Only sizes 1, 2 and 4 are legal. Any other reqSize value ends with doneStatus 2'b01 (invalid) and makes no bus access.
- R2: Bus 0 selects a Type 0 access. With bus 0, a device number of 16 or more ends with status 2'b01 and no bus access.
- R3: For Type 0, the select bit sits at position device+16. Select bits at or above bit 26 appear in winSel, the rest appear in extAddr. winSel[1:0] reads 2'b10 for Type 0, and 2'b10 is also the value after reset.
- R4: extAddr carries the function number in bits 10:8 and the offset with its two low bits cleared in bits 7:0.
- R5: A non-zero bus selects Type 1. extAddr is bus<<16 | device<<11 | function<<8 | aligned offset, and winSel is 32'h3.
- R6: When singleSlot is high at acceptance, any device number other than 0 ends with status 2'b01 and no bus access, whatever the bus number.
- R7: A read returns the dword shifted right by 8*offset[1:0], masked to 8 bits for size 1 and to 16 bits for size 2.
- R8: A 1- or 2-byte write reads the dword, replaces the lane that starts at byte offset[1:0], and writes the dword back. Bytes that would fall past bit 31 are dropped. A 4-byte write makes one bus write and no read.
- R9: A faulted access ends with status 2'b10 and doneRdata 32'hFFFFFFFF. A fault on the read of a read-modify-write suppresses the write-back.
- R10: reqReady is high only when idle and drops from acceptance until the done pulse. doneValid lasts exactly one cycle, and status 2'b00 means success.
- R11: extReq, extAddr and extWe stay stable until extAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| singleSlot | input | 1 | Only device 0 may be addressed |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Engine idle, request accepted when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOff | input | 8 | Register byte offset |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Write data, right-aligned |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 00 ok, 01 invalid, 10 bus fault |
| doneRdata | output | 32 | Aligned read result |
| extReq | output | 1 | Bus access request, held until acknowledge |
| extWe | output | 1 | Bus access is a write |
| extAddr | output | 32 | Dword address of the access |
| extWdata | output | 32 | Dword to write |
| winSel | output | 32 | Window register: upper select bits and mode code |
| extAck | input | 1 | Access complete |
| extFault | input | 1 | Access faulted, valid with extAck |
| extRdata | input | 32 | Read dword, valid with extAck |

## Verification
Reads are tried at every byte offset with every legal size. This separates the lane shift from the size mask, including a halfword at offset 3 that overruns the dword. Type 0 devices on both sides of the window boundary (9, 10, 15) show whether a select bit went to the address or to the window. Type 1 requests with all-ones fields show that no field overlaps another. Sub-word writes followed by read-back separate the merge from plain overwrite, and the bench's read and write counts tell a read-modify-write from a single write. Fault addresses, illegal sizes, out-of-range devices, single-slot mode and a slow acknowledge check that rejections make no bus access and that the request holds steady while it waits.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_FAULT   = 2'd2
  } cfgStatus_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } cfgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadWin;
    logic loadWdata;
    logic loadRead;
    logic loadMerge;
    logic loadOnes;
  } dpStrobe_t;

  localparam logic [1:0] WIN_MODE_T0 = 2'b10;
  localparam logic [1:0] WIN_MODE_T1 = 2'b11;

endpackage

// File: rtl/cfg_access_dp.sv
module cfg_access_dp
  import cfg_access_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FUNC_W  = 3,
  parameter int OFF_W   = 8,
  parameter int SLOTS   = 16,
  parameter int SEL_LSB = 16,
  parameter int WIN_LSB = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic              singleSlot,
  input  logic [31:0]       extRdata,
  output logic              reqBad,
  output logic              fullWrite,
  output logic              isWrite,
  output logic [31:0]       extAddr,
  output logic [31:0]       winSel,
  output logic [31:0]       dataWord
);

  localparam logic [31:0] WIN_MASK = ~((32'd1 << WIN_LSB) - 32'd1);

  logic [BUS_W-1:0]  busReg;
  logic [DEV_W-1:0]  devReg;
  logic [FUNC_W-1:0] funcReg;
  logic [OFF_W-1:0]  offReg;
  logic [2:0]        sizeReg;
  logic              wrReg;
  logic              slotReg;
  logic [31:0]       wdReg;
  logic [31:0]       dataReg;
  logic [31:0]       winReg;

  logic        sizeOk;
  logic        isType1;
  logic [31:0] selWord;
  logic [31:0] offAligned;
  logic [31:0] type0Addr;
  logic [31:0] type1Addr;
  logic [4:0]  laneShift;
  logic [31:0] laneMask;
  logic [31:0] mergedWord;
  logic [31:0] readWord;
  logic [31:0] winNext;

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReg  <= '0;
      devReg  <= '0;
      funcReg <= '0;
      offReg  <= '0;
      sizeReg <= '0;
      wrReg   <= 1'b0;
      slotReg <= 1'b0;
      wdReg   <= '0;
    end else if (strobe.capture) begin
      busReg  <= reqBus;
      devReg  <= reqDev;
      funcReg <= reqFunc;
      offReg  <= reqOff;
      sizeReg <= reqSize;
      wrReg   <= reqWrite;
      slotReg <= singleSlot;
      wdReg   <= reqWdata;
    end
  end

  always_comb begin
    case (sizeReg)
      3'd1, 3'd2, 3'd4: sizeOk = 1'b1;
      default:          sizeOk = 1'b0;
    endcase
  end

  assign isType1 = |busReg;

  // one-hot device select across the slot range
  always_comb begin
    selWord = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (32'(devReg) == i) selWord[SEL_LSB + i] = 1'b1;
    end
  end

  assign offAligned = 32'({offReg[OFF_W-1:2], 2'b00});
  assign type0Addr  = (selWord & ~WIN_MASK) | (32'(funcReg) << 8) | offAligned;
  assign type1Addr  = (32'(busReg) << 16) | (32'(devReg) << 11)
                    | (32'(funcReg) << 8) | offAligned;
  assign extAddr    = isType1 ? type1Addr : type0Addr;
  assign winNext    = isType1 ? {30'd0, WIN_MODE_T1}
                              : ((selWord & WIN_MASK) | {30'd0, WIN_MODE_T0});

  assign reqBad = !sizeOk
               || (!isType1 && (32'(devReg) >= SLOTS))
               || (slotReg && (devReg != '0));

  assign fullWrite = wrReg && (sizeReg == 3'd4);
  assign isWrite   = wrReg;

  // byte lane handling
  assign laneShift = {offReg[1:0], 3'b000};

  always_comb begin
    case (sizeReg)
      3'd1:    laneMask = 32'h0000_00FF << laneShift;
      3'd2:    laneMask = 32'h0000_FFFF << laneShift;
      default: laneMask = 32'hFFFF_FFFF;
    endcase
  end

  assign mergedWord = (extRdata & ~laneMask) | ((wdReg << laneShift) & laneMask);
  assign readWord   = (extRdata >> laneShift) & (laneMask >> laneShift);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobe.loadOnes) begin
      dataReg <= 32'hFFFF_FFFF;
    end else if (strobe.loadMerge) begin
      dataReg <= mergedWord;
    end else if (strobe.loadRead) begin
      dataReg <= readWord;
    end else if (strobe.loadWdata) begin
      dataReg <= wdReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winReg <= {30'd0, WIN_MODE_T0};
    end else if (strobe.loadWin) begin
      winReg <= winNext;
    end
  end

  assign winSel   = winReg;
  assign dataWord = dataReg;

endmodule

// File: rtl/cfg_access_ctrl.sv
module cfg_access_ctrl
  import cfg_access_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqBad,
  input  logic       fullWrite,
  input  logic       isWrite,
  input  logic       extAck,
  input  logic       extFault,
  output dpStrobe_t  strobe,
  output logic       reqReady,
  output logic       extReq,
  output logic       extWe,
  output logic       doneValid,
  output logic [1:0] doneStatus
);

  cfgState_e  state, nextState;
  cfgStatus_e status, nextStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      status <= ST_OK;
    end else begin
      state  <= nextState;
      status <= nextStatus;
    end
  end

  always_comb begin
    strobe     = '0;
    nextState  = state;
    nextStatus = status;
    extReq     = 1'b0;
    extWe      = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = S_CHECK;
        end
      end
      S_CHECK: begin
        if (reqBad) begin
          nextStatus = ST_INVALID;
          nextState  = S_DONE;
        end else begin
          strobe.loadWin = 1'b1;
          if (fullWrite) begin
            strobe.loadWdata = 1'b1;
            nextState        = S_WRITE;
          end else begin
            nextState = S_READ;
          end
        end
      end
      S_READ: begin
        extReq = 1'b1;
        if (extAck) begin
          if (extFault) begin
            strobe.loadOnes = 1'b1;
            nextStatus      = ST_FAULT;
            nextState       = S_DONE;
          end else if (isWrite) begin
            strobe.loadMerge = 1'b1;
            nextState        = S_WRITE;
          end else begin
            strobe.loadRead = 1'b1;
            nextStatus      = ST_OK;
            nextState       = S_DONE;
          end
        end
      end
      S_WRITE: begin
        extReq = 1'b1;
        extWe  = 1'b1;
        if (extAck) begin
          if (extFault) begin
            strobe.loadOnes = 1'b1;
            nextStatus      = ST_FAULT;
          end else begin
            nextStatus = ST_OK;
          end
          nextState = S_DONE;
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady   = (state == S_IDLE);
  assign doneValid  = (state == S_DONE);
  assign doneStatus = status;

endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine
  import cfg_access_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FUNC_W  = 3,
  parameter int OFF_W   = 8,
  parameter int SLOTS   = 16,
  parameter int SEL_LSB = 16,
  parameter int WIN_LSB = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              singleSlot,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [2:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [31:0]       doneRdata,
  output logic              extReq,
  output logic              extWe,
  output logic [31:0]       extAddr,
  output logic [31:0]       extWdata,
  output logic [31:0]       winSel,
  input  logic              extAck,
  input  logic              extFault,
  input  logic [31:0]       extRdata
);

  dpStrobe_t   strobe;
  logic        reqBad;
  logic        fullWrite;
  logic        isWrite;
  logic [31:0] dataWord;

  cfg_access_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqBad     (reqBad),
    .fullWrite  (fullWrite),
    .isWrite    (isWrite),
    .extAck     (extAck),
    .extFault   (extFault),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .extReq     (extReq),
    .extWe      (extWe),
    .doneValid  (doneValid),
    .doneStatus (doneStatus)
  );

  cfg_access_dp #(
    .BUS_W   (BUS_W),
    .DEV_W   (DEV_W),
    .FUNC_W  (FUNC_W),
    .OFF_W   (OFF_W),
    .SLOTS   (SLOTS),
    .SEL_LSB (SEL_LSB),
    .WIN_LSB (WIN_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqBus     (reqBus),
    .reqDev     (reqDev),
    .reqFunc    (reqFunc),
    .reqOff     (reqOff),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .singleSlot (singleSlot),
    .extRdata   (extRdata),
    .reqBad     (reqBad),
    .fullWrite  (fullWrite),
    .isWrite    (isWrite),
    .extAddr    (extAddr),
    .winSel     (winSel),
    .dataWord   (dataWord)
  );

  assign extWdata  = dataWord;
  assign doneRdata = dataWord;

endmodule

// File: rtl/cfg_access_engine_chk.sv
module cfg_access_engine_chk #(
  parameter int SEL_LSB = 16,
  parameter int WIN_LSB = 26
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        doneValid,
  input logic [1:0]  doneStatus,
  input logic [31:0] doneRdata,
  input logic        extReq,
  input logic        extWe,
  input logic        extAck,
  input logic        extFault,
  input logic [31:0] extAddr,
  input logic [31:0] winSel
);

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10

  AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !extReq); // R10

  AST_TYPE0_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && winSel[1:0] == 2'b10) |->
      $countones({winSel[31:WIN_LSB], extAddr[WIN_LSB-1:SEL_LSB]}) == 1); // R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> extAddr[1:0] == 2'b00); // R4

  AST_FAULT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 2'd2) |-> doneRdata == 32'hFFFF_FFFF); // R9

  AST_NO_WB_AFTER_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && !extWe && extAck && extFault) |=> (!extReq && doneValid)); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (extReq && !extAck) |=> (extReq && $stable(extAddr) && $stable(extWe))); // R11

endmodule

bind cfg_access_engine cfg_access_engine_chk #(
  .SEL_LSB (SEL_LSB),
  .WIN_LSB (WIN_LSB)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .doneValid  (doneValid),
  .doneStatus (doneStatus),
  .doneRdata  (doneRdata),
  .extReq     (extReq),
  .extWe      (extWe),
  .extAck     (extAck),
  .extFault   (extFault),
  .extAddr    (extAddr),
  .winSel     (winSel)
);

// File: tb/test_cfg_access_engine.sv
`timescale 1ns/1ps
module test_cfg_access_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        singleSlot = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [7:0]  reqOff = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        doneValid;
  logic [1:0]  doneStatus;
  logic [31:0] doneRdata;
  logic        extReq;
  logic        extWe;
  logic [31:0] extAddr;
  logic [31:0] extWdata;
  logic [31:0] winSel;
  logic        extAck = 1'b0;
  logic        extFault = 1'b0;
  logic [31:0] extRdata = '0;

  always #2 clk = ~clk;

  cfg_access_engine i_cfg_access_engine (
    .clk(clk), .rstN(rstN), .singleSlot(singleSlot),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqOff(reqOff),
    .reqSize(reqSize), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneStatus(doneStatus), .doneRdata(doneRdata),
    .extReq(extReq), .extWe(extWe), .extAddr(extAddr), .extWdata(extWdata),
    .winSel(winSel), .extAck(extAck), .extFault(extFault), .extRdata(extRdata)
  );

  // ---------------- bus model ----------------
  logic [31:0] mem [logic [31:0]];
  logic [31:0] faultAddr = 32'hFFFF_FFFF;
  int          lat = 0;
  int          waitCnt = 0;
  logic [31:0] holdAddr;
  logic        holdWe;
  logic [31:0] lastAddr = '0;
  logic [31:0] lastWin = '0;
  int          rdCount = 0;
  int          wrCount = 0;
  int          mCmp = 0, mBad = 0;

  function automatic logic [31:0] memPeek(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'h5A3C_0F96);
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      extAck  <= 1'b0;
      waitCnt = 0;
    end else if (extReq && !extAck) begin
      if (waitCnt == 0) begin
        holdAddr = extAddr;
        holdWe   = extWe;
      end else begin
        mCmp++;
        if (extAddr !== holdAddr || extWe !== holdWe) begin
          mBad++;
          $display("FAIL R11 held request changed: addr %h we %b expected %h %b",
                   extAddr, extWe, holdAddr, holdWe);
        end
      end
      if (waitCnt >= lat) begin
        extAck   <= 1'b1;
        extFault <= (extAddr == faultAddr);
        extRdata <= memPeek(extAddr);
        lastAddr = extAddr;
        lastWin  = winSel;
        if (extWe) begin
          wrCount++;
          if (extAddr != faultAddr) mem[extAddr] = extWdata;
        end else begin
          rdCount++;
        end
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end else begin
      extAck  <= 1'b0;
      waitCnt = 0;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [1:0]  status;
    logic [31:0] rdata;
    bit          chkData;
    bit          chkAddr;
    logic [31:0] addr;
    logic [31:0] win;
    int          nRd;
    int          nWr;
    bit          chkMem;
    logic [31:0] memWord;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   expRd = 0, expWr = 0;
  int   nCmp = 0, nBad = 0;
  int   dCmp = 0, dBad = 0;
  bit   finished = 1'b0;

  task automatic doReq(input bit wr, input int bus, input int dev, input int func,
                       input int off, input int size, input logic [31:0] wd,
                       input string tag);
    exp_t        e;
    bit          bad;
    logic [63:0] sel;
    logic [31:0] old, v, w;
    bit          faulty;
    e = '{status: 2'd0, rdata: '0, chkData: 1'b0, chkAddr: 1'b0, addr: '0,
          win: '0, nRd: 0, nWr: 0, chkMem: 1'b0, memWord: '0, tag: tag};
    bad = !(size == 1 || size == 2 || size == 4) || (bus == 0 && dev >= 16)
          || (singleSlot && dev >= 1);
    if (bad) begin
      e.status = 2'd1;
    end else begin
      e.chkAddr = 1'b1;
      if (bus == 0) begin
        sel    = 64'd1 << (dev + 16);
        e.addr = (sel[31:0] & 32'h03FF_FFFF) | (32'(func) << 8) | (32'(off) & 32'hFC);
        e.win  = (sel[31:0] & 32'hFC00_0000) | 32'h2;
      end else begin
        e.addr = (32'(bus) << 16) | (32'(dev) << 11) | (32'(func) << 8)
               | (32'(off) & 32'hFC);
        e.win  = 32'h3;
      end
      faulty = (e.addr == faultAddr);
      old    = memPeek(e.addr);
      if (!wr) begin
        expRd++;
        e.chkData = 1'b1;
        if (faulty) begin
          e.status = 2'd2; e.rdata = 32'hFFFF_FFFF;
        end else begin
          v = old >> (8 * (off % 4));
          if (size == 1) v = v & 32'hFF;
          if (size == 2) v = v & 32'hFFFF;
          e.status = 2'd0; e.rdata = v;
        end
      end else if (size == 4) begin
        expWr++;
        if (faulty) begin
          e.status = 2'd2; e.chkData = 1'b1; e.rdata = 32'hFFFF_FFFF;
        end else begin
          e.status = 2'd0; e.chkMem = 1'b1; e.memWord = wd;
        end
      end else begin
        expRd++;
        if (faulty) begin
          e.status = 2'd2; e.chkData = 1'b1; e.rdata = 32'hFFFF_FFFF;
        end else begin
          expWr++;
          w = old;
          for (int i = 0; i < size; i++) begin
            int p = (off % 4) + i;
            if (p < 4) w[p*8 +: 8] = wd[i*8 +: 8];
          end
          e.status = 2'd0; e.chkMem = 1'b1; e.memWord = w;
        end
      end
    end
    e.nRd = expRd;
    e.nWr = expWr;
    sbq.push_back(e);

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr;
    reqBus   = 8'(bus);
    reqDev   = 5'(dev);
    reqFunc  = 3'(func);
    reqOff   = 8'(off);
    reqSize  = 3'(size);
    reqWdata = wd;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    dCmp++;
    if (reqReady !== 1'b0) begin
      dBad++;
      $display("FAIL R10 reqReady while busy: got %b expected 0", reqReady);
    end
    while (sbq.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN && doneValid) begin
      exp_t e;
      if (sbq.size() == 0) begin
        nCmp++; nBad++;
        $display("FAIL R10 unexpected done: got status %0d expected no completion", doneStatus);
      end else begin
        e = sbq.pop_front();
        nCmp++;
        if (doneStatus !== e.status) begin
          nBad++;
          $display("FAIL %s status: got %0d expected %0d", e.tag, doneStatus, e.status);
        end
        if (e.chkData) begin
          nCmp++;
          if (doneRdata !== e.rdata) begin
            nBad++;
            $display("FAIL %s rdata: got %h expected %h", e.tag, doneRdata, e.rdata);
          end
        end
        if (e.chkAddr) begin
          nCmp++;
          if (lastAddr !== e.addr || lastWin !== e.win) begin
            nBad++;
            $display("FAIL %s addr/win: got %h/%h expected %h/%h", e.tag,
                     lastAddr, lastWin, e.addr, e.win);
          end
        end
        nCmp++;
        if (rdCount != e.nRd || wrCount != e.nWr) begin
          nBad++;
          $display("FAIL %s bus cycles rd/wr: got %0d/%0d expected %0d/%0d", e.tag,
                   rdCount, wrCount, e.nRd, e.nWr);
        end
        if (e.chkMem) begin
          nCmp++;
          if (memPeek(e.addr) !== e.memWord) begin
            nBad++;
            $display("FAIL %s stored word: got %h expected %h", e.tag,
                     memPeek(e.addr), e.memWord);
          end
        end
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             nCmp + dCmp + mCmp, nBad + dBad + mBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      dCmp++; dBad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: R10 and R3
    dCmp++;
    if (reqReady !== 1'b1 || doneValid !== 1'b0 || extReq !== 1'b0) begin
      dBad++;
      $display("FAIL R10 reset handshake: got rdy %b done %b req %b expected 1 0 0",
               reqReady, doneValid, extReq);
    end
    dCmp++;
    if (winSel !== 32'h2) begin
      dBad++;
      $display("FAIL R3 reset window: got %h expected 00000002", winSel);
    end

    // R7 / R4 reads over offsets and sizes
    doReq(0, 0, 0, 0, 8'h00, 4, 0, "R7 dword read");
    doReq(0, 0, 0, 0, 8'h01, 1, 0, "R7 byte off1");
    doReq(0, 0, 1, 0, 8'h06, 2, 0, "R7 half off2");
    doReq(0, 0, 1, 0, 8'h0B, 2, 0, "R7 half off3");
    doReq(0, 0, 3, 5, 8'h3D, 1, 0, "R4 func/offset");
    doReq(0, 0, 2, 7, 8'hFF, 4, 0, "R4 top offset");

    // R3 window boundary
    doReq(0, 0, 9, 0, 8'h04, 4, 0, "R3 dev9 in addr");
    doReq(0, 0, 10, 1, 8'h08, 4, 0, "R3 dev10 in window");
    doReq(0, 0, 15, 2, 8'h0C, 4, 0, "R3 dev15 in window");

    // R2 / R1 rejections
    doReq(0, 0, 16, 0, 8'h00, 4, 0, "R2 dev16 rejected");
    doReq(1, 0, 31, 0, 8'h00, 4, 32'h1234, "R2 dev31 rejected");
    doReq(0, 0, 1, 0, 8'h00, 0, 0, "R1 size0");
    doReq(0, 0, 1, 0, 8'h00, 3, 0, "R1 size3");
    doReq(1, 2, 1, 0, 8'h00, 7, 32'hFFFF, "R1 size7");

    // R5 Type 1
    doReq(0, 3, 21, 6, 8'h47, 4, 0, "R5 type1");
    doReq(0, 255, 31, 7, 8'hFE, 2, 0, "R5 type1 all ones");
    doReq(0, 1, 16, 0, 8'h10, 1, 0, "R5 type1 dev16 legal");

    // R8 writes with read-back
    doReq(1, 0, 2, 0, 8'h10, 4, 32'hCAFE_F00D, "R8 dword write");
    doReq(1, 0, 2, 0, 8'h13, 1, 32'h0000_00AB, "R8 byte lane3");
    doReq(1, 0, 2, 0, 8'h11, 2, 32'h0000_5566, "R8 half lane1");
    doReq(0, 0, 2, 0, 8'h10, 4, 0, "R8 readback");
    doReq(1, 0, 2, 0, 8'h13, 2, 32'h0000_7788, "R8 half overrun");
    doReq(1, 4, 5, 3, 8'h22, 2, 32'h0000_9ABC, "R8 type1 half");
    doReq(0, 4, 5, 3, 8'h20, 4, 0, "R8 type1 readback");

    // R9 faults
    faultAddr = 32'h0010_0120;
    doReq(0, 0, 4, 1, 8'h21, 1, 0, "R9 read fault");
    doReq(1, 0, 4, 1, 8'h20, 2, 32'h1111, "R9 rmw fault");
    doReq(1, 0, 4, 1, 8'h20, 4, 32'h2222_3333, "R9 write fault");
    faultAddr = 32'hFFFF_FFFF;

    // R11 slow acknowledge
    lat = 3;
    doReq(0, 0, 6, 2, 8'h30, 4, 0, "R11 slow read");
    doReq(1, 0, 6, 2, 8'h31, 1, 32'h0000_0042, "R11 slow rmw");
    lat = 0;

    // R6 single-slot mode
    singleSlot = 1'b1;
    doReq(0, 0, 1, 0, 8'h00, 4, 0, "R6 dev1 rejected");
    doReq(0, 2, 3, 0, 8'h00, 4, 0, "R6 type1 dev3 rejected");
    doReq(0, 0, 0, 0, 8'h08, 4, 0, "R6 dev0 allowed");
    singleSlot = 1'b0;

    doReq(0, 0, 0, 0, 8'h00, 4, 0, "R10 back to normal");

    repeat (4) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule